// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sits beside a processor and moves it between the running state and three depths of low-power operation. Software selects a depth on a mode input and then executes its wait-for-interrupt instruction, which arrives as a one-cycle trigger. The controller then drives the processor clock gate, the internal and external oscillator enables, the PLL enable and the core regulator enable. It watches the wake sources and runs the exit sequence that belongs to the chosen depth.

The lightest depth only stops the processor clock, and any wake source ends it. The middle depth switches off every high-speed clock source but keeps state. It listens only to the low-speed sources, which are external-line events and real-time-clock events. On exit it waits for the internal oscillator to report ready before the processor clock reopens, and it leaves the system clock on the internal oscillator. The deepest depth also turns the regulator off, so retained state is lost. A wake from it produces a one-cycle system reset request instead of a resume.

The external-line and real-time-clock inputs are asynchronous. They pass through a synchroniser before the controller acts on them. A sticky status reports which depth was left last and which sources woke it. A separate flag records that the deepest depth was entered. Software clears both with a write-one pulse.

Top module: `lpc_ctrl`

## Requirements
- R1: After reset: cpu_clk_en=1, hsi_en=1, reg_en=1, retain=1; hse_en, pll_en, clk_sel_pll and sys_rst_req are 0; sts_mode=00, sts_src=000 and stby_flag=0.
- R2: Entry starts only on a cycle with wfi=1 and mode_req other than 00. Mode codes are 01 light (sleep), 10 middle (stop) and 11 deep (standby). Without wfi, or with mode_req=00, the outputs do not change.
- R3: Two rising edges after the entry trigger, sleep drops cpu_clk_en while every oscillator, PLL and regulator enable keeps its value. Any wake source (irq, ext_evt, rtc_evt) reopens the clock.
- R4: In stop, hsi_en, hse_en, pll_en and cpu_clk_en are 0 while reg_en and retain stay 1. The irq input is ignored in this state.
- R5: A stop exit comes only from ext_evt or rtc_evt. It first raises hsi_en with cpu_clk_en still 0, and it reopens cpu_clk_en on the first rising edge that sees hsi_rdy=1.
- R6: After a stop exit, hse_en, pll_en and clk_sel_pll stay 0 until an osc_restore pulse in the running state. That pulse sets all three on the next edge.
- R7: Standby drives reg_en=0 and retain=0, switches off every oscillator, and sets stby_flag. An ext_evt or rtc_evt wake raises sys_rst_req for exactly one cycle, and the controller is then running again. irq is ignored in standby.
- R8: A wake source allowed for the requested depth, present in the cycle after the trigger, aborts the entry. The clock stays open and the status is not written.
- R9: At each exit, sts_mode takes the mode code of the depth left and sts_src its wake sources (bit0 irq, bit1 ext_evt, bit2 rtc_evt). The status holds until sts_clr=1 clears it and stby_flag. An exit in the same cycle as a clear wins.
- R10: A level on ext_evt or rtc_evt takes effect on the third rising edge after it is applied. Earlier edges do not change the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 2 | Requested depth: 00 none, 01 sleep, 10 stop, 11 standby |
| wfi | input | 1 | Wait-for-interrupt trigger pulse |
| irq | input | 1 | General interrupt, synchronous to clk |
| ext_evt | input | 1 | External-line wake event, asynchronous |
| rtc_evt | input | 1 | Real-time-clock alarm or wakeup event, asynchronous |
| hsi_rdy | input | 1 | Internal oscillator ready |
| osc_restore | input | 1 | Software pulse to re-enable external oscillator and PLL |
| sts_clr | input | 1 | Write-one clear of status and standby flag |
| cpu_clk_en | output | 1 | Processor clock gate enable |
| hsi_en | output | 1 | Internal oscillator enable |
| hse_en | output | 1 | External oscillator enable |
| pll_en | output | 1 | PLL enable |
| clk_sel_pll | output | 1 | System clock select: 1 PLL, 0 internal oscillator |
| reg_en | output | 1 | Core regulator enable |
| retain | output | 1 | State retention valid |
| sys_rst_req | output | 1 | One-cycle system reset request after standby wake |
| sts_mode | output | 2 | Mode code of the depth last exited |
| sts_src | output | 3 | Wake sources of the last exit |
| stby_flag | output | 1 | Standby was entered since the last clear |

## Verification
The properties assume that rst is high at the first clock edge. They also assume that irq, hsi_rdy, wfi, mode_req, osc_restore and sts_clr change only between edges. Only the two event inputs may arrive without regard to the clock. The stimulus changes every input one nanosecond after a rising edge. It never clears the status while the controller is in standby, and it holds each event level until the controller has left the depth. It then releases the level and waits for the synchroniser to drain before the next entry.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam int MODE_W = 2;
  localparam int SRC_W  = 3;
  localparam int SRC_IRQ = 0;
  localparam int SRC_EXT = 1;
  localparam int SRC_RTC = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_NONE  = 2'b00,
    MODE_SLEEP = 2'b01,
    MODE_STOP  = 2'b10,
    MODE_STBY  = 2'b11
  } lp_mode_e;

  typedef enum logic [2:0] {
    ST_RUN, ST_ENTER, ST_SLEEP, ST_STOP, ST_STBY, ST_HSI_WAIT, ST_RST
  } lp_state_e;

  // Sources that may end a given depth: low-speed sources always, irq only in sleep
  function automatic logic [SRC_W-1:0] wake_mask(lp_mode_e m);
    logic [SRC_W-1:0] msk;
    msk = '0;
    msk[SRC_EXT] = 1'b1;
    msk[SRC_RTC] = 1'b1;
    if (m == MODE_SLEEP) msk[SRC_IRQ] = 1'b1;
    return msk;
  endfunction
endpackage

// File: rtl/lpc_sync.sv
module lpc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lpc_fsm.sv
module lpc_fsm
  import lpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_req,
  input  logic              wfi,
  input  logic [SRC_W-1:0]  wake,
  input  logic              hsi_rdy,
  input  logic              osc_restore,
  output logic              cpu_clk_en,
  output logic              hsi_en,
  output logic              hse_en,
  output logic              pll_en,
  output logic              reg_en,
  output logic              retain,
  output logic              sys_rst_req,
  output logic              hsi_wait,
  output logic              stby_enter,
  output logic              exit_vld,
  output logic [MODE_W-1:0] exit_mode,
  output logic [SRC_W-1:0]  exit_src
);
  lp_state_e        st_q, st_d;
  lp_mode_e         mode_q, mode_d;
  logic [SRC_W-1:0] src_q, src_d, hit;
  logic             osc_off_d;

  always_comb begin
    st_d      = st_q;
    mode_d    = mode_q;
    src_d     = src_q;
    exit_vld  = 1'b0;
    exit_src  = src_q;
    hit       = wake & wake_mask(mode_q);
    unique case (st_q)
      ST_RUN: if (wfi && mode_req != MODE_NONE) begin
        st_d   = ST_ENTER;
        mode_d = lp_mode_e'(mode_req);
      end
      ST_ENTER: begin
        if (|hit)                    st_d = ST_RUN;
        else if (mode_q == MODE_SLEEP) st_d = ST_SLEEP;
        else if (mode_q == MODE_STOP)  st_d = ST_STOP;
        else                           st_d = ST_STBY;
      end
      ST_SLEEP: if (|hit) begin
        st_d     = ST_RUN;
        exit_vld = 1'b1;
        exit_src = hit;
      end
      ST_STOP: if (|hit) begin
        st_d  = ST_HSI_WAIT;
        src_d = hit;
      end
      ST_HSI_WAIT: if (hsi_rdy) begin
        st_d     = ST_RUN;
        exit_vld = 1'b1;
      end
      ST_STBY: if (|hit) begin
        st_d  = ST_RST;
        src_d = hit;
      end
      ST_RST: begin
        st_d     = ST_RUN;
        exit_vld = 1'b1;
      end
      default: st_d = ST_RUN;
    endcase
  end

  assign exit_mode  = mode_q;
  assign hsi_wait   = (st_q == ST_HSI_WAIT);
  assign stby_enter = (st_q == ST_ENTER) && (st_d == ST_STBY);
  assign osc_off_d  = (st_d == ST_STOP) || (st_d == ST_STBY);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_RUN;
      mode_q      <= MODE_NONE;
      src_q       <= '0;
      cpu_clk_en  <= 1'b1;
      hsi_en      <= 1'b1;
      hse_en      <= 1'b0;
      pll_en      <= 1'b0;
      reg_en      <= 1'b1;
      retain      <= 1'b1;
      sys_rst_req <= 1'b0;
    end else begin
      st_q        <= st_d;
      mode_q      <= mode_d;
      src_q       <= src_d;
      cpu_clk_en  <= (st_d == ST_RUN) || (st_d == ST_ENTER);
      hsi_en      <= !osc_off_d;
      reg_en      <= (st_d != ST_STBY);
      retain      <= !((st_d == ST_STBY) || (st_d == ST_RST));
      sys_rst_req <= (st_d == ST_RST);
      if (osc_off_d) begin
        hse_en <= 1'b0;
        pll_en <= 1'b0;
      end else if (osc_restore && st_q == ST_RUN && st_d == ST_RUN) begin
        hse_en <= 1'b1;
        pll_en <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lpc_status.sv
module lpc_status
  import lpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              exit_vld,
  input  logic [MODE_W-1:0] exit_mode,
  input  logic [SRC_W-1:0]  exit_src,
  input  logic              stby_enter,
  input  logic              sts_clr,
  output logic [MODE_W-1:0] sts_mode,
  output logic [SRC_W-1:0]  sts_src,
  output logic              stby_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sts_mode  <= '0;
      sts_src   <= '0;
      stby_flag <= 1'b0;
    end else begin
      if (exit_vld) begin
        sts_mode <= exit_mode;
        sts_src  <= exit_src;
      end else if (sts_clr) begin
        sts_mode <= '0;
        sts_src  <= '0;
      end
      if (stby_enter)   stby_flag <= 1'b1;
      else if (sts_clr) stby_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/lpc_ctrl.sv
module lpc_ctrl
  import lpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_req,
  input  logic              wfi,
  input  logic              irq,
  input  logic              ext_evt,
  input  logic              rtc_evt,
  input  logic              hsi_rdy,
  input  logic              osc_restore,
  input  logic              sts_clr,
  output logic              cpu_clk_en,
  output logic              hsi_en,
  output logic              hse_en,
  output logic              pll_en,
  output logic              clk_sel_pll,
  output logic              reg_en,
  output logic              retain,
  output logic              sys_rst_req,
  output logic [MODE_W-1:0] sts_mode,
  output logic [SRC_W-1:0]  sts_src,
  output logic              stby_flag
);
  localparam int LS_W = SRC_W - 1;

  logic [LS_W-1:0]   ls_sync;
  logic [SRC_W-1:0]  wake;
  logic              hsi_wait, stby_enter, exit_vld;
  logic [MODE_W-1:0] exit_mode;
  logic [SRC_W-1:0]  exit_src;

  lpc_sync #(.WIDTH(LS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({rtc_evt, ext_evt}),
    .q   (ls_sync)
  );

  always_comb begin
    wake          = '0;
    wake[SRC_IRQ] = irq;
    wake[SRC_EXT] = ls_sync[0];
    wake[SRC_RTC] = ls_sync[1];
  end

  lpc_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .mode_req    (mode_req),
    .wfi         (wfi),
    .wake        (wake),
    .hsi_rdy     (hsi_rdy),
    .osc_restore (osc_restore),
    .cpu_clk_en  (cpu_clk_en),
    .hsi_en      (hsi_en),
    .hse_en      (hse_en),
    .pll_en      (pll_en),
    .reg_en      (reg_en),
    .retain      (retain),
    .sys_rst_req (sys_rst_req),
    .hsi_wait    (hsi_wait),
    .stby_enter  (stby_enter),
    .exit_vld    (exit_vld),
    .exit_mode   (exit_mode),
    .exit_src    (exit_src)
  );

  // PLL is selected only while it is enabled, so any stop or standby exit lands on the internal oscillator
  assign clk_sel_pll = pll_en;

  lpc_status u_status (
    .clk        (clk),
    .rst        (rst),
    .exit_vld   (exit_vld),
    .exit_mode  (exit_mode),
    .exit_src   (exit_src),
    .stby_enter (stby_enter),
    .sts_clr    (sts_clr),
    .sts_mode   (sts_mode),
    .sts_src    (sts_src),
    .stby_flag  (stby_flag)
  );
endmodule

// File: rtl/lpc_ctrl_chk.sv
module lpc_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       hsi_rdy,
  input logic       hsi_wait,
  input logic       cpu_clk_en,
  input logic       hsi_en,
  input logic       hse_en,
  input logic       pll_en,
  input logic       reg_en,
  input logic       retain,
  input logic       sys_rst_req,
  input logic [1:0] sts_mode,
  input logic [2:0] sts_src,
  input logic       stby_flag
);
  p_osc_off_r4: assert property (@(posedge clk) disable iff (rst)
    !hsi_en |-> (!hse_en && !pll_en && !cpu_clk_en));

  p_retain_stop_r4: assert property (@(posedge clk) disable iff (rst)
    (!hsi_en && reg_en) |-> retain);

  p_hsi_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (hsi_wait && !hsi_rdy) |=> !cpu_clk_en);

  p_stop_src_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(cpu_clk_en) && sts_mode == 2'b10) |-> !sts_src[0]);

  p_rst_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |=> !sys_rst_req);

  p_rst_after_stby_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_req) |-> $past(!reg_en));

  p_stby_flag_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(reg_en) |-> (stby_flag && !retain));

  p_sts_on_exit_r9: assert property (@(posedge clk) disable iff (rst)
    (sts_src != 3'b000 && !$stable(sts_src)) |-> $rose(cpu_clk_en));
endmodule

bind lpc_ctrl lpc_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .hsi_rdy     (hsi_rdy),
  .hsi_wait    (hsi_wait),
  .cpu_clk_en  (cpu_clk_en),
  .hsi_en      (hsi_en),
  .hse_en      (hse_en),
  .pll_en      (pll_en),
  .reg_en      (reg_en),
  .retain      (retain),
  .sys_rst_req (sys_rst_req),
  .sts_mode    (sts_mode),
  .sts_src     (sts_src),
  .stby_flag   (stby_flag)
);

// File: tb/lpc_ctrl_test.sv
`timescale 1ns/1ps
module lpc_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_req = 2'b00;
  logic       wfi = 1'b0, irq = 1'b0, ext_evt = 1'b0, rtc_evt = 1'b0;
  logic       hsi_rdy = 1'b0, osc_restore = 1'b0, sts_clr = 1'b0;
  logic       cpu_clk_en, hsi_en, hse_en, pll_en, clk_sel_pll, reg_en, retain, sys_rst_req, stby_flag;
  logic [1:0] sts_mode;
  logic [2:0] sts_src;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [4:0] exp_q [$];
  logic [4:0] prev_sts = '0;

  always #2 clk = ~clk;

  lpc_ctrl uut (
    .clk(clk), .rst(rst), .mode_req(mode_req), .wfi(wfi), .irq(irq),
    .ext_evt(ext_evt), .rtc_evt(rtc_evt), .hsi_rdy(hsi_rdy),
    .osc_restore(osc_restore), .sts_clr(sts_clr),
    .cpu_clk_en(cpu_clk_en), .hsi_en(hsi_en), .hse_en(hse_en), .pll_en(pll_en),
    .clk_sel_pll(clk_sel_pll), .reg_en(reg_en), .retain(retain),
    .sys_rst_req(sys_rst_req), .sts_mode(sts_mode), .sts_src(sts_src),
    .stby_flag(stby_flag)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_exit(input logic [1:0] m, input logic [2:0] s);
    exp_q.push_back({m, s});
  endtask

  task automatic enter(input logic [1:0] m);
    mode_req = m; wfi = 1'b1;
    step(1);
    wfi = 1'b0;
    step(1);
  endtask

  task automatic clear_sts();
    sts_clr = 1'b1; step(1); sts_clr = 1'b0;
  endtask

  // Monitor: each new nonzero status must match the next expected exit (R9)
  always @(negedge clk) begin
    if (!rst) begin
      if ({sts_mode, sts_src} != prev_sts && {sts_mode, sts_src} != 5'b0) begin
        n_run++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R9: actual %0h expected none", {sts_mode, sts_src});
        end else begin
          logic [4:0] e;
          e = exp_q.pop_front();
          if (e !== {sts_mode, sts_src}) begin
            n_fail++;
            $display("FAIL R9: actual %0h expected %0h", {sts_mode, sts_src}, e);
          end
        end
      end
      prev_sts <= {sts_mode, sts_src};
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #80000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    // R1 reset state
    check("R1 cpu_clk_en", cpu_clk_en, 1); check("R1 hsi_en", hsi_en, 1);
    check("R1 hse_en", hse_en, 0);         check("R1 pll_en", pll_en, 0);
    check("R1 reg_en", reg_en, 1);         check("R1 retain", retain, 1);
    check("R1 sys_rst_req", sys_rst_req, 0);
    check("R1 status", {stby_flag, sts_mode, sts_src}, 0);

    // R6 software restore of external oscillator and PLL
    osc_restore = 1'b1; step(1); osc_restore = 1'b0;
    check("R6 restore", {hse_en, pll_en, clk_sel_pll}, 3'b111);

    // R2 no trigger, or trigger with no mode
    mode_req = 2'b10; step(3);
    check("R2 no wfi", {cpu_clk_en, hsi_en, pll_en}, 3'b111);
    mode_req = 2'b00; wfi = 1'b1; step(3); wfi = 1'b0;
    check("R2 mode none", {cpu_clk_en, hsi_en, pll_en}, 3'b111);

    // R3 sleep, irq wake
    enter(2'b01);
    check("R3 sleep gate", cpu_clk_en, 0);
    check("R3 sleep clocks", {hsi_en, hse_en, pll_en, reg_en, retain}, 5'b11111);
    expect_exit(2'b01, 3'b001);
    irq = 1'b1; step(1); irq = 1'b0;
    check("R3 irq wake", cpu_clk_en, 1);
    step(1);

    // R10 sleep woken by external line through synchroniser
    clear_sts();
    check("R9 clear", {sts_mode, sts_src}, 0);
    enter(2'b01);
    expect_exit(2'b01, 3'b010);
    ext_evt = 1'b1; step(2);
    check("R10 not yet", cpu_clk_en, 0);
    step(1);
    check("R10 third edge", cpu_clk_en, 1);
    ext_evt = 1'b0; step(3);

    // R8 abort during entry
    clear_sts();
    mode_req = 2'b01; wfi = 1'b1; irq = 1'b1; step(1); wfi = 1'b0;
    step(1); irq = 1'b0;
    check("R8 abort gate", cpu_clk_en, 1);
    step(1);
    check("R8 abort gate held", cpu_clk_en, 1);
    check("R8 no status", {sts_mode, sts_src}, 0);

    // R4 stop entry, irq ignored; R5 exit sequence
    hsi_rdy = 1'b0;
    irq = 1'b1;
    enter(2'b10);
    check("R4 stop off", {hsi_en, hse_en, pll_en, cpu_clk_en}, 4'b0000);
    check("R4 retained", {reg_en, retain}, 2'b11);
    step(3);
    check("R4 irq ignored", {hsi_en, cpu_clk_en}, 2'b00);
    irq = 1'b0;
    expect_exit(2'b10, 3'b100);
    rtc_evt = 1'b1; step(3);
    check("R5 hsi first", {hsi_en, cpu_clk_en}, 2'b10);
    rtc_evt = 1'b0; step(4);
    check("R5 wait ready", cpu_clk_en, 0);
    hsi_rdy = 1'b1; step(1);
    check("R5 reopen", cpu_clk_en, 1);
    check("R6 stay off", {hse_en, pll_en, clk_sel_pll}, 3'b000);
    step(3);
    check("R6 still off", {hse_en, pll_en}, 2'b00);
    osc_restore = 1'b1; step(1); osc_restore = 1'b0;
    check("R6 re-enabled", {hse_en, pll_en, clk_sel_pll}, 3'b111);

    // R9 exit in the same cycle as a clear wins
    enter(2'b01);
    expect_exit(2'b01, 3'b001);
    irq = 1'b1; sts_clr = 1'b1; step(1); irq = 1'b0; sts_clr = 1'b0;
    check("R9 exit wins", {sts_mode, sts_src}, 5'b01001);

    // R7 standby
    clear_sts();
    enter(2'b11);
    check("R7 regulator off", {reg_en, retain}, 2'b00);
    check("R7 osc off", {hsi_en, hse_en, pll_en}, 3'b000);
    check("R7 flag", {stby_flag, sys_rst_req}, 2'b10);
    irq = 1'b1; step(2); irq = 1'b0;
    check("R7 irq ignored", {reg_en, sys_rst_req}, 2'b00);
    expect_exit(2'b11, 3'b010);
    ext_evt = 1'b1; step(3);
    check("R7 reset request", {sys_rst_req, reg_en, cpu_clk_en}, 3'b110);
    step(1);
    check("R7 reset pulse end", {sys_rst_req, cpu_clk_en}, 2'b01);
    check("R9 standby status", {stby_flag, sts_mode, sts_src}, 6'b111010);
    ext_evt = 1'b0; step(3);
    clear_sts();
    check("R9 clear flag", {stby_flag, sts_mode, sts_src}, 0);

    step(2);
    check("R9 all exits seen", exp_q.size(), 0);
    finish_run();
  end
endmodule